// File: doc/BRIEF.md
# Branch Unit with Circular Return Stack

This unit decides where a paged coprocessor fetches next. Every cycle the core hands it the instruction word, the four condition flags (negative, zero, carry, overflow), the 8-bit address within the current page and the value of its 15-bit page-select register. The unit answers, in the same cycle, with the next in-page address, the next program page and a flag that tells the core to suppress the instruction that follows.

It covers unconditional and conditional jumps, unconditional and conditional subroutine calls, returns and conditional skips. Conditions only ever test a flag for being set. Each jump or call may also switch to the page held in the page-select input. The unit holds the active page in its own register. Return points live in an internal ring of eight 23-bit entries, and each entry holds the page followed by the address. The ring never reports overflow or underflow: a ninth call silently replaces the oldest entry, and a return from an empty ring reads whatever entry the wrapped pointer lands on.

Top module: `brUnit`

## Requirements
- R1: After reset the active page is 0x00FF. While instValid is low, pcNext equals pcCur, pageNext equals the active page and skipNext is 0.
- R2: A word with bits [15:10] = 000010 jumps to bits [7:0]. If bit 9 (far) is 1, pageNext takes pageP; otherwise the page is unchanged.
- R3: Words with bits [15:10] = 000011, 000100, 000101 or 000110 jump as in R2 only when Z, C, N or V is 1, respectively. Otherwise pcNext is pcCur+1, wrapping from 0xFF to 0x00, and the page is kept.
- R4: Words with bits [15:10] = 001010 (always), 001011 (Z), 001100 (C), 001101 (N) or 001110 (V) are calls. A taken call jumps as in R2 and pushes {active page, pcCur+1}. A call that is not taken pushes nothing and advances by one.
- R5: A word with bits [15:10] = 001111 returns. pageNext and pcNext take the most recent pushed entry that has not yet been popped.
- R6: The ring holds 8 entries. After nine pushes, pops return the 9th, 8th, ..., 2nd pushed values and then the 9th again.
- R7: A return right after reset, with nothing pushed, yields page 0 and address 0.
- R8: A word with bits [15:10] = 001001 is a skip. Bits [9:8] select the flag (00 V, 01 C, 10 Z, 11 N). skipNext is 1 when that flag equals bit 0. pcNext is pcCur+1 either way.
- R9: Every other word has no effect on the ring or the page: pcNext is pcCur+1 and skipNext is 0. This covers bits [15:10] = 000000, 000001, 000111 and 001000, and any word whose bits [15:14] are not 00.
- R10: The active page register keeps the last pageNext. After a far jump, later instructions see the new page until another far jump or return changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented this cycle |
| instWord | input | 16 | Instruction word |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| pcCur | input | 8 | Address within the page of the current instruction |
| pageP | input | 15 | Page-select register value used by far jumps and calls |
| pcNext | output | 8 | Next address within the page |
| pageNext | output | 15 | Next program page |
| skipNext | output | 1 | Suppress the following instruction |

## Verification
Random words are drawn mostly from the branch opcode space, with random flags, addresses and page values, so every condition code meets both flag polarities and the far bit is tried both ways. A reference model of the ring tracks the state across long mixes of calls and returns, which separates a correct pointer from one that is off by one or misses the wrap. Directed sequences cover the cases random stimulus rarely reaches: a return with nothing pushed, nine calls followed by ten returns, the not-taken advance from 0xFF, and every skip selector with both expected values. Each of these patterns separates a flag-selection or wrap error from a correct design.

// File: rtl/brPkg.sv
package brPkg;
  // control strobes from the decoder to the datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic jump;
    logic farLoad;
    logic skip;
  } brStrobe_t;

  localparam logic [2:0] GRP_JUMP = 3'b000;
  localparam logic [2:0] GRP_CALL = 3'b001;
  localparam logic [5:0] OP_RET   = 6'b001111;
  localparam logic [5:0] OP_SKIP  = 6'b001001;

  // condition codes live in word bits [12:10]; 010 means always
  function automatic logic condDefined(input logic [2:0] code);
    return (code >= 3'b010) && (code <= 3'b110);
  endfunction

  function automatic logic condHit(input logic [2:0] code, input logic n,
                                   input logic z, input logic c, input logic v);
    case (code)
      3'b010:  return 1'b1;
      3'b011:  return z;
      3'b100:  return c;
      3'b101:  return n;
      3'b110:  return v;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/brCtrl.sv
module brCtrl
  import brPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [7:0] opHi,
  input  logic       expectBit,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagC,
  input  logic       flagV,
  output brStrobe_t  strobe
);
  logic [2:0] grp;
  logic [2:0] code;
  logic       isJump;
  logic       isCall;
  logic       isRet;
  logic       isSkip;
  logic       taken;
  logic       skipFlag;

  assign grp    = opHi[7:5];
  assign code   = opHi[4:2];
  assign isJump = (grp == GRP_JUMP) && condDefined(code);
  assign isCall = (grp == GRP_CALL) && condDefined(code);
  assign isRet  = (opHi[7:2] == OP_RET);
  assign isSkip = (opHi[7:2] == OP_SKIP);
  assign taken  = condHit(code, flagN, flagZ, flagC, flagV);

  always_comb begin
    case (opHi[1:0])
      2'b00:   skipFlag = flagV;
      2'b01:   skipFlag = flagC;
      2'b10:   skipFlag = flagZ;
      default: skipFlag = flagN;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.jump    = instValid && (isJump || isCall) && taken;
    strobe.push    = instValid && isCall && taken;
    strobe.pop     = instValid && isRet;
    strobe.farLoad = strobe.jump && opHi[1];
    strobe.skip    = instValid && isSkip && (skipFlag == expectBit);
  end

  // R9
  exclusive_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.jump, strobe.pop, strobe.skip}));
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int PC_W     = 8,
  parameter int PAGE_W   = 15,
  parameter int DEPTH    = 8,
  parameter logic [PAGE_W-1:0] PAGE_RST = 15'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  brStrobe_t         strobe,
  input  logic [PC_W-1:0]   target,
  input  logic [PC_W-1:0]   pcCur,
  input  logic [PAGE_W-1:0] pageP,
  output logic [PC_W-1:0]   pcNext,
  output logic [PAGE_W-1:0] pageNext
);
  localparam int RET_W = PAGE_W + PC_W;
  localparam int PTR_W = $clog2(DEPTH);

  logic [RET_W-1:0]  stackMem [DEPTH];
  logic [DEPTH-1:0]  wrEn;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptrPrev;
  logic [RET_W-1:0]  topEntry;
  logic [RET_W-1:0]  pushVal;
  logic [PAGE_W-1:0] pageQ;
  logic [PC_W-1:0]   seqPc;

  assign seqPc    = pcCur + PC_W'(1);
  assign pushVal  = {pageQ, seqPc};
  assign ptrPrev  = ptr - PTR_W'(1);
  assign topEntry = stackMem[ptrPrev];

  for (genvar i = 0; i < DEPTH; i++) begin : g_wr
    assign wrEn[i] = strobe.push && (ptr == PTR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stackMem[i] <= '0;
      ptr <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wrEn[i]) stackMem[i] <= pushVal;
      if (strobe.push)     ptr <= ptr + PTR_W'(1);
      else if (strobe.pop) ptr <= ptrPrev;
    end
  end

  always_comb begin
    pcNext   = pcCur;
    pageNext = pageQ;
    if (strobe.pop) begin
      {pageNext, pcNext} = topEntry;
    end else if (strobe.jump) begin
      pcNext = target;
      if (strobe.farLoad) pageNext = pageP;
    end else if (instValid) begin
      pcNext = seqPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pageQ <= PAGE_RST;
    else       pageQ <= pageNext;
  end

  // R1
  reset_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> pageQ == PAGE_RST);
  // R5
  push_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> topEntry == $past(pushVal));
  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pop && !strobe.farLoad) |=> $stable(pageQ));
endmodule

// File: rtl/brUnit.sv
module brUnit
  import brPkg::*;
#(
  parameter int PC_W     = 8,
  parameter int PAGE_W   = 15,
  parameter int DEPTH    = 8,
  parameter logic [PAGE_W-1:0] PAGE_RST = 15'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              flagV,
  input  logic [PC_W-1:0]   pcCur,
  input  logic [PAGE_W-1:0] pageP,
  output logic [PC_W-1:0]   pcNext,
  output logic [PAGE_W-1:0] pageNext,
  output logic              skipNext
);
  brStrobe_t strobe;

  brCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid),
    .opHi(instWord[15:8]), .expectBit(instWord[0]),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .strobe(strobe)
  );

  brDatapath #(.PC_W(PC_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .PAGE_RST(PAGE_RST)) u_dp (
    .clk(clk), .rstN(rstN), .instValid(instValid), .strobe(strobe),
    .target(instWord[PC_W-1:0]), .pcCur(pcCur), .pageP(pageP),
    .pcNext(pcNext), .pageNext(pageNext)
  );

  assign skipNext = strobe.skip;

  // R8
  skip_sequential_chk: assert property (@(posedge clk) disable iff (!rstN)
    skipNext |-> pcNext == pcCur + PC_W'(1));
endmodule

// File: tb/sim_brUnit.sv
module sim_brUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] instWord = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic [7:0]  pcCur = '0;
  logic [14:0] pageP = '0;
  logic [7:0]  pcNext;
  logic [14:0] pageNext;
  logic        skipNext;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [14:0] mPage;
  logic [22:0] mStack [8];
  int          mPtr;

  always #5 clk = ~clk;

  brUnit u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .pcCur(pcCur), .pageP(pageP),
    .pcNext(pcNext), .pageNext(pageNext), .skipNext(skipNext)
  );

  function automatic string classify(input logic [15:0] w);
    logic [2:0] c;
    c = w[12:10];
    if (w[15:10] == 6'b001111) return "R5";
    if (w[15:10] == 6'b001001) return "R8";
    if (w[15:10] == 6'b000010) return "R2";
    if (w[15:13] == 3'b000 && c >= 3 && c <= 6) return "R3";
    if (w[15:13] == 3'b001 && c >= 2 && c <= 6) return "R4";
    return "R9";
  endfunction

  task automatic step(input logic v, input logic [15:0] w, input logic [3:0] nzcv,
                      input logic [7:0] pc, input logic [14:0] p, input string tag);
    logic [7:0]  ePc;
    logic [14:0] ePage;
    logic        eSkip, doPush, doPop, hit, f;
    logic [2:0]  c;
    @(negedge clk);
    instValid = v; instWord = w; {flagN, flagZ, flagC, flagV} = nzcv;
    pcCur = pc; pageP = p;
    #2;
    ePc = v ? pc + 8'd1 : pc;
    ePage = mPage; eSkip = 0; doPush = 0; doPop = 0;
    c = w[12:10];
    if (v) begin
      hit = (c == 2) || (c == 3 && nzcv[2]) || (c == 4 && nzcv[1]) ||
            (c == 5 && nzcv[3]) || (c == 6 && nzcv[0]);
      if (w[15:10] == 6'b001111) begin
        {ePage, ePc} = mStack[(mPtr + 7) % 8];
        doPop = 1;
      end else if (w[15:10] == 6'b001001) begin
        case (w[9:8])
          2'b00: f = nzcv[0];
          2'b01: f = nzcv[1];
          2'b10: f = nzcv[2];
          default: f = nzcv[3];
        endcase
        eSkip = (f == w[0]);
      end else if ((w[15:13] == 3'b000 || w[15:13] == 3'b001) && c >= 2 && c <= 6 && hit) begin
        ePc = w[7:0];
        if (w[9]) ePage = p;
        doPush = (w[15:13] == 3'b001);
      end
    end
    total++;
    if (pcNext !== ePc || pageNext !== ePage || skipNext !== eSkip) begin
      bad++;
      $display("FAIL %s: word=%h pc=%h/%h page=%h/%h skip=%b/%b (actual/expected)",
               tag, w, pcNext, ePc, pageNext, ePage, skipNext, eSkip);
    end
    @(posedge clk);
    if (doPush) begin
      mStack[mPtr] = {mPage, pc + 8'd1};
      mPtr = (mPtr + 1) % 8;
    end else if (doPop) begin
      mPtr = (mPtr + 7) % 8;
    end
    mPage = ePage;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    mPage = 15'h00FF; mPtr = 0;
    for (int i = 0; i < 8; i++) mStack[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 idle after reset
    step(1'b0, 16'h0A10, 4'hF, 8'h33, 15'h1111, "R1");
    // R7 return with nothing pushed
    step(1'b1, 16'h3C00, 4'h0, 8'h10, 15'h0000, "R7");
    // R2 far and near jumps
    step(1'b1, 16'h0A42, 4'h0, 8'h05, 15'h1234, "R2");
    step(1'b1, 16'h0855, 4'h0, 8'h06, 15'h7777, "R2");
    // R3 each condition, not taken (wrap) and taken
    step(1'b1, 16'h0E20, 4'b1011, 8'hFF, 15'h0AAA, "R3");
    step(1'b1, 16'h0E20, 4'b0100, 8'hFF, 15'h0AAA, "R3");
    step(1'b1, 16'h1030, 4'b1101, 8'h40, 15'h0BBB, "R3");
    step(1'b1, 16'h1030, 4'b0010, 8'h40, 15'h0BBB, "R3");
    step(1'b1, 16'h1440, 4'b0111, 8'h41, 15'h0CCC, "R3");
    step(1'b1, 16'h1440, 4'b1000, 8'h41, 15'h0CCC, "R3");
    step(1'b1, 16'h1850, 4'b1110, 8'h42, 15'h0DDD, "R3");
    step(1'b1, 16'h1A50, 4'b0001, 8'h42, 15'h0DDD, "R3");
    // R4 call taken, call not taken, then R5 return
    step(1'b1, 16'h2A80, 4'h0, 8'h21, 15'h0123, "R4");
    step(1'b1, 16'h2C90, 4'b1011, 8'h81, 15'h0456, "R4");
    step(1'b1, 16'h3C00, 4'h0, 8'h82, 15'h0000, "R5");
    // R6 nine calls then ten returns
    for (int i = 0; i < 9; i++)
      step(1'b1, 16'h2A00 | 16'(i * 16), 4'h0, 8'(i * 3), 15'(16'h0100 + i), "R6");
    for (int i = 0; i < 10; i++)
      step(1'b1, 16'h3C00, 4'h0, 8'h00, 15'h0000, "R6");
    // R8 every selector, both expected values
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++) begin
        step(1'b1, 16'h2400 | 16'(s << 8) | 16'(e), 4'b1010, 8'h70, 15'h0, "R8");
        step(1'b1, 16'h2400 | 16'(s << 8) | 16'(e), 4'b0101, 8'h71, 15'h0, "R8");
      end
    // R9 undefined words and non-branch words, then a return shows ring intact
    step(1'b1, 16'h2A00, 4'h0, 8'h90, 15'h0555, "R9");
    step(1'b1, 16'h0000, 4'hF, 8'h91, 15'h0666, "R9");
    step(1'b1, 16'h0700, 4'hF, 8'h92, 15'h0666, "R9");
    step(1'b1, 16'h1F00, 4'hF, 8'h93, 15'h0666, "R9");
    step(1'b1, 16'h23FF, 4'hF, 8'h94, 15'h0666, "R9");
    step(1'b1, 16'h6100, 4'hF, 8'hFF, 15'h0666, "R9");
    step(1'b1, 16'hFFFF, 4'hF, 8'h95, 15'h0666, "R9");
    step(1'b1, 16'h3C00, 4'h0, 8'h96, 15'h0000, "R9");
    // R10 page persists after far jump
    step(1'b1, 16'h0B11, 4'h0, 8'h20, 15'h3ABC, "R10");
    step(1'b1, 16'h0C22, 4'h0, 8'h12, 15'h0001, "R10");
    step(1'b1, 16'h0933, 4'h0, 8'h13, 15'h0002, "R10");
    // random mix weighted to the branch opcode space
    for (int i = 0; i < 800; i++) begin
      logic [15:0] w;
      w = 16'($urandom());
      if (($urandom() % 8) != 0) w[15:14] = 2'b00;
      step(($urandom() % 16) != 0, w, 4'($urandom()), 8'($urandom()),
           15'($urandom()), classify(w));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule